// File: doc/BRIEF.md
# Nibble-Mode Indexed Register Bridge

This block sits on the adapter side of a parallel host link. It turns host activity on an 8-bit data bus and a 6-bit control bus into single-cycle read and write strobes towards a disk register file. The host never addresses anything directly. It first selects an adapter register by latching an index. It then writes a byte into that register. The two operations carry the same data lines and differ only in the shape of the train of control values that frames them. Adapter register 1 holds the disk register number and a bank-select bit. Register 2 holds the transfer mode. Selecting register 0 opens the data path to the addressed disk register.

The mode selects either nibble or byte transfers, and either single-register or block operation. In nibble mode, read data comes back four bits at a time on the upper status lines, low half first. In byte mode, the adapter drives the whole byte back onto the data lines while the host holds the direction bit of the control bus. A disk write in single mode needs two data pulses. The first only stages the value, and the second commits it. In block mode every pulse commits. Latching index 4 twice in a row marks the end of a session and restores the default settings.

Top module: `nibble_reg_bridge`

## Requirements
- R1: After reset, no strobe is issued, `host_oe` is 0, `host_stat` is 0, the mode is nibble single, the address is 0, and adapter index 0 is selected.
- R2: The control sequence 0x05, 0x0D, 0x05, 0x0D, 0x05, 0x04 latches the adapter index. Only changes of `host_ctl` count as steps. The index is taken from `host_din` in the cycle of the final 0x04.
- R3: The control sequence 0x05, 0x07, 0x05, 0x04 writes `host_din`, taken in the cycle of the final 0x04, into the selected adapter register. For index 1, bits [2+AW-1:2] give the disk register number and bit 1 gives the bank select, so `rb_addr` = {bank, number}.
- R4: A change of `host_ctl` to a value that is not the next step of either sequence abandons the partial sequence. A change to 0x05 starts a new one. An abandoned sequence changes no register.
- R5: With index 0 selected in single mode, the first write sequence only stages the value. The second issues `rb_wr` for one cycle with the second value on `rb_wdata`. A third write stages again.
- R6: Writing index 2 with 0x08 selects nibble single, 0x09 byte single, 0x18 nibble block and 0x19 byte block. Any other value leaves the mode unchanged.
- R7: In nibble single mode with index 0 selected, the first change to 0x06 issues `rb_rd` and shows bits [3:0] of the read byte on `host_stat`. The second shows bits [7:4]. The third and fourth issue no read and leave `host_stat` unchanged.
- R8: In byte single mode, the first change to 0x26 issues `rb_rd`, and the byte appears on `host_dout`. `host_oe` equals bit 5 of `host_ctl` while index 0 is selected. The second change to 0x26 issues no read.
- R9: In nibble block mode, every change to 0x06 issues `rb_rd` and shows the low nibble. A change from 0x06 to 0x04 then shows the high nibble.
- R10: In byte block mode, a change to 0x26 issues `rb_rd`. A change from 0x26 to 0x24 issues a further `rb_rd`.
- R11: In either block mode, every write sequence on index 0 commits at once with `rb_wr`.
- R12: While the selected index is not 0, no `rb_rd` and no `rb_wr` is issued. `rb_rd` and `rb_wr` are never high together.
- R13: Two index latches of 0x04 in a row, with no write sequence between them, restore nibble single mode and address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_din | input | DW | Host data lines |
| host_ctl | input | 6 | Host control lines (bit 5 = read direction) |
| host_dout | output | DW | Byte returned in byte mode |
| host_oe | output | 1 | Adapter drives `host_dout` |
| host_stat | output | DW/2 | Upper status lines carrying a nibble |
| rb_rd | output | 1 | Disk register read strobe |
| rb_wr | output | 1 | Disk register write strobe |
| rb_addr | output | AW+1 | Bank select and disk register number |
| rb_wdata | output | DW | Disk write data |
| rb_rdata | input | DW | Disk read data, valid in the cycle of `rb_rd` |

## Verification
The completion of an index latch and the restore of defaults for a disconnect land in the same cycle when the second 0x04 latch ends. The same holds for a committing data write and the clearing of the read phase. The bench provokes both. It ends a disconnect while byte mode is active. It also reads right after a commit. It then judges the next cycle's `host_oe` and nibble order against a behavioural model that tracks the control history in a queue. A stray control value inside each pattern checks that abandonment leaves the index and the stored disk bytes intact.

// File: rtl/nbb_pkg.sv
package nbb_pkg;

  localparam int CTL_W = 6;
  localparam int CTL_DIR_BIT = 5;

  localparam logic [CTL_W-1:0] CTL_REST = 6'h04;
  localparam logic [CTL_W-1:0] CTL_ARM  = 6'h05;
  localparam logic [CTL_W-1:0] CTL_IDX  = 6'h0D;
  localparam logic [CTL_W-1:0] CTL_WR   = 6'h07;
  localparam logic [CTL_W-1:0] CTL_NSTB = 6'h06;
  localparam logic [CTL_W-1:0] CTL_BSTB = 6'h26;
  localparam logic [CTL_W-1:0] CTL_BNXT = 6'h24;

  typedef enum logic [2:0] {
    RS_IDLE, RS_ARM, RS_I1, RS_I2, RS_I3, RS_I4, RS_W1, RS_W2
  } rs_t;

  typedef struct packed {
    rs_t  st;
    logic idx_done;
    logic wr_done;
  } rs_step_t;

  typedef struct packed {
    logic blk;
    logic byte_x;
  } mode_t;

  localparam mode_t MODE_DEFAULT = '{blk: 1'b0, byte_x: 1'b0};

  function automatic rs_step_t rs_next(rs_t st, logic [CTL_W-1:0] c);
    rs_step_t r;
    r.idx_done = 1'b0;
    r.wr_done  = 1'b0;
    r.st       = (c == CTL_ARM) ? RS_ARM : RS_IDLE;
    case (st)
      RS_ARM: begin
        if (c == CTL_IDX)     r.st = RS_I1;
        else if (c == CTL_WR) r.st = RS_W1;
      end
      RS_I1: if (c == CTL_ARM) r.st = RS_I2;
      RS_I2: if (c == CTL_IDX) r.st = RS_I3;
      RS_I3: if (c == CTL_ARM) r.st = RS_I4;
      RS_I4: if (c == CTL_REST) begin
        r.st = RS_IDLE;
        r.idx_done = 1'b1;
      end
      RS_W1: if (c == CTL_ARM) r.st = RS_W2;
      RS_W2: if (c == CTL_REST) begin
        r.st = RS_IDLE;
        r.wr_done = 1'b1;
      end
      default: ;
    endcase
    return r;
  endfunction

  function automatic logic mode_code_ok(logic [7:0] v);
    return (v == 8'h08) || (v == 8'h09) || (v == 8'h18) || (v == 8'h19);
  endfunction

  function automatic mode_t mode_from_code(logic [7:0] v);
    mode_t m;
    m.blk    = v[4];
    m.byte_x = v[0];
    return m;
  endfunction

endpackage

// File: rtl/nbb_ctl_recog.sv
module nbb_ctl_recog
  import nbb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] ctl,
  input  logic             chg,
  output logic             idx_done,
  output logic             wr_done
);

  rs_t      st_q;
  rs_step_t nx;

  always_comb begin
    nx       = rs_next(st_q, ctl);
    idx_done = chg && nx.idx_done;
    wr_done  = chg && nx.wr_done;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   st_q <= RS_IDLE;
    else if (chg) st_q <= nx.st;
  end

  logic stray;
  assign stray = chg && (st_q != RS_IDLE) &&
                 !((ctl == CTL_REST) || (ctl == CTL_ARM) ||
                   (ctl == CTL_WR) || (ctl == CTL_IDX));

  assert_stray_resets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stray |=> (st_q == RS_IDLE));

  assert_done_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({idx_done, wr_done}));

endmodule

// File: rtl/nbb_reg_core.sv
module nbb_reg_core
  import nbb_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idx_done,
  input  logic          wr_done,
  input  logic [DW-1:0] din,
  output logic          path_open,
  output mode_t         mode_q,
  output logic [AW:0]   disk_addr,
  output logic          commit,
  output logic          seq_clear
);

  localparam logic [DW-1:0] IDX_DATA = DW'(0);
  localparam logic [DW-1:0] IDX_ADDR = DW'(1);
  localparam logic [DW-1:0] IDX_MODE = DW'(2);
  localparam logic [DW-1:0] IDX_PARK = DW'(4);

  logic [DW-1:0] index_q;
  logic [AW-1:0] reg_q;
  logic          sel_q;
  logic          staged_q;
  logic          last4_q;
  logic          disc;

  assign path_open = (index_q == IDX_DATA);
  assign disc      = idx_done && (din == IDX_PARK) && last4_q;
  assign commit    = wr_done && path_open && (mode_q.blk || staged_q);
  assign seq_clear = idx_done || wr_done;
  assign disk_addr = {sel_q, reg_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      index_q  <= IDX_DATA;
      mode_q   <= MODE_DEFAULT;
      reg_q    <= '0;
      sel_q    <= 1'b0;
      staged_q <= 1'b0;
      last4_q  <= 1'b0;
    end else if (idx_done) begin
      staged_q <= 1'b0;
      index_q  <= din;
      if (disc) begin
        mode_q  <= MODE_DEFAULT;
        reg_q   <= '0;
        sel_q   <= 1'b0;
        last4_q <= 1'b0;
      end else begin
        last4_q <= (din == IDX_PARK);
      end
    end else if (wr_done) begin
      last4_q <= 1'b0;
      if (path_open) staged_q <= !commit;
      if (index_q == IDX_ADDR) begin
        reg_q <= din[2 +: AW];
        sel_q <= din[1];
      end
      if (index_q == IDX_MODE && mode_code_ok(din[7:0]))
        mode_q <= mode_from_code(din[7:0]);
    end
  end

  assert_index_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    idx_done |=> (index_q == $past(din)));

  assert_first_pulse_stages_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done && path_open && !mode_q.blk && !staged_q) |=> staged_q);

  assert_commit_unstages_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !staged_q);

  assert_mode_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_q) |-> ($past(wr_done) || $past(disc)));

  assert_park_defaults_R13: assert property (@(posedge clk) disable iff (!rst_n)
    disc |=> (mode_q == MODE_DEFAULT) && (disk_addr == '0));

endmodule

// File: rtl/nbb_read_path.sv
module nbb_read_path
  import nbb_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CTL_W-1:0] ctl,
  input  logic [CTL_W-1:0] ctl_prev,
  input  logic             chg,
  input  logic             path_open,
  input  mode_t            mode,
  input  logic             seq_clear,
  input  logic [DW-1:0]    rdata,
  output logic             fetch,
  output logic [DW/2-1:0]  stat,
  output logic [DW-1:0]    dout,
  output logic             oe
);

  localparam int HW = DW / 2;

  function automatic logic [HW-1:0] nib_pick(logic [DW-1:0] b, logic hi);
    return hi ? b[DW-1:HW] : b[HW-1:0];
  endfunction

  logic [1:0]    phase_q, phase_d;
  logic          hi_q, hi_set;
  logic [DW-1:0] buf_q;

  always_comb begin
    fetch   = 1'b0;
    hi_set  = 1'b0;
    phase_d = phase_q;
    if (chg && path_open && !seq_clear) begin
      case ({mode.byte_x, mode.blk})
        2'b00: if (ctl == CTL_NSTB) begin
          fetch   = (phase_q == 2'd0);
          hi_set  = (phase_q == 2'd1);
          phase_d = phase_q + 2'd1;
        end
        2'b01: begin
          fetch  = (ctl == CTL_NSTB);
          hi_set = (ctl == CTL_REST) && (ctl_prev == CTL_NSTB);
        end
        2'b10: if (ctl == CTL_BSTB) begin
          fetch   = (phase_q == 2'd0);
          phase_d = (phase_q == 2'd0) ? 2'd1 : 2'd0;
        end
        default:
          fetch = (ctl == CTL_BSTB) ||
                  ((ctl == CTL_BNXT) && (ctl_prev == CTL_BSTB));
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= 2'd0;
      hi_q    <= 1'b0;
      buf_q   <= '0;
    end else if (seq_clear) begin
      phase_q <= 2'd0;
      hi_q    <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (fetch) begin
        buf_q <= rdata;
        hi_q  <= 1'b0;
      end else if (hi_set) begin
        hi_q <= 1'b1;
      end
    end
  end

  assign stat = nib_pick(buf_q, hi_q);
  assign dout = buf_q;
  assign oe   = path_open && mode.byte_x && ctl[CTL_DIR_BIT];

  assert_low_nibble_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && !mode.byte_x) |=> (stat == $past(rdata[HW-1:0])));

  assert_byte_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch && mode.byte_x) |=> (dout == $past(rdata)));

endmodule

// File: rtl/nibble_reg_bridge.sv
module nibble_reg_bridge
  import nbb_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    host_din,
  input  logic [CTL_W-1:0] host_ctl,
  output logic [DW-1:0]    host_dout,
  output logic             host_oe,
  output logic [DW/2-1:0]  host_stat,
  output logic             rb_rd,
  output logic             rb_wr,
  output logic [AW:0]      rb_addr,
  output logic [DW-1:0]    rb_wdata,
  input  logic [DW-1:0]    rb_rdata
);

  logic [CTL_W-1:0] ctl_prev_q;
  logic             chg;
  logic             idx_done, wr_done;
  logic             path_open, seq_clear;
  mode_t            mode_q;

  assign chg = (host_ctl != ctl_prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_prev_q <= CTL_REST;
    else        ctl_prev_q <= host_ctl;
  end

  nbb_ctl_recog u_recog (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctl      (host_ctl),
    .chg      (chg),
    .idx_done (idx_done),
    .wr_done  (wr_done)
  );

  nbb_reg_core #(.DW(DW), .AW(AW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_done  (idx_done),
    .wr_done   (wr_done),
    .din       (host_din),
    .path_open (path_open),
    .mode_q    (mode_q),
    .disk_addr (rb_addr),
    .commit    (rb_wr),
    .seq_clear (seq_clear)
  );

  nbb_read_path #(.DW(DW)) u_read (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (host_ctl),
    .ctl_prev  (ctl_prev_q),
    .chg       (chg),
    .path_open (path_open),
    .mode      (mode_q),
    .seq_clear (seq_clear),
    .rdata     (rb_rdata),
    .fetch     (rb_rd),
    .stat      (host_stat),
    .dout      (host_dout),
    .oe        (host_oe)
  );

  assign rb_wdata = host_din;

  assert_strobes_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(rb_rd && rb_wr));

  assert_closed_path_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !path_open |-> !(rb_rd || rb_wr));

endmodule

// File: tb/test_nibble_reg_bridge.sv
module test_nibble_reg_bridge;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] host_din = 8'h00;
  logic [5:0] host_ctl = 6'h04;
  logic [7:0] host_dout;
  logic       host_oe;
  logic [3:0] host_stat;
  logic       rb_rd, rb_wr;
  logic [3:0] rb_addr;
  logic [7:0] rb_wdata;
  logic [7:0] rb_rdata;
  logic [7:0] disk [16];

  always #5 clk = ~clk;

  nibble_reg_bridge i_nibble_reg_bridge (
    .clk(clk), .rst_n(rst_n), .host_din(host_din), .host_ctl(host_ctl),
    .host_dout(host_dout), .host_oe(host_oe), .host_stat(host_stat),
    .rb_rd(rb_rd), .rb_wr(rb_wr), .rb_addr(rb_addr), .rb_wdata(rb_wdata),
    .rb_rdata(rb_rdata)
  );

  assign rb_rdata = disk[rb_addr];
  always @(posedge clk) if (rb_wr) disk[rb_addr] <= rb_wdata;

  int checks = 0;
  int errors = 0;
  string cur_tag = "R1";

  int pat_idx [6] = '{5, 13, 5, 13, 5, 4};
  int pat_wr  [4] = '{5, 7, 5, 4};
  int hist [$];
  int m_prev, m_idx, m_reg, m_sel, m_byte, m_blk, m_staged, m_last4;
  int m_phase, m_hi, m_buf;
  int mdisk [16];
  int obs_stat, obs_out, obs_oe;
  int n_rd, n_wr;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int pat_el(int w, int k);
    return (w == 0) ? pat_idx[k] : pat_wr[k];
  endfunction

  function automatic int judge(int w);
    int len = (w == 0) ? 6 : 4;
    if (hist.size() > len) return 0;
    for (int k = 0; k < hist.size(); k++)
      if (hist[k] != pat_el(w, k)) return 0;
    return (hist.size() == len) ? 2 : 1;
  endfunction

  task automatic step(int c, int d);
    bit chg, ie, we, rd, wr, sethi, oe;
    int a, ji, jw, nphase, estat;
    ie = 0; we = 0; rd = 0; wr = 0; sethi = 0;
    @(negedge clk);
    host_ctl = c[5:0];
    host_din = d[7:0];
    #1;
    chg = (c != m_prev);
    if (chg) begin
      hist.push_back(c);
      ji = judge(0);
      jw = judge(1);
      if (ji == 2) begin ie = 1; hist.delete(); end
      else if (jw == 2) begin we = 1; hist.delete(); end
      else if (ji == 0 && jw == 0) begin
        hist.delete();
        if (c == 5) hist.push_back(5);
      end
    end
    a = m_sel * 8 + m_reg;
    nphase = m_phase;
    if (we && m_idx == 0 && (m_blk || m_staged)) wr = 1;
    if (chg && m_idx == 0 && !ie && !we) begin
      if (!m_byte && !m_blk) begin
        if (c == 6) begin
          rd = (m_phase == 0);
          sethi = (m_phase == 1);
          nphase = (m_phase + 1) % 4;
        end
      end else if (!m_byte && m_blk) begin
        rd = (c == 6);
        sethi = (c == 4 && m_prev == 6);
      end else if (m_byte && !m_blk) begin
        if (c == 'h26) begin
          rd = (m_phase == 0);
          nphase = (m_phase == 0) ? 1 : 0;
        end
      end else begin
        rd = (c == 'h26) || (c == 'h24 && m_prev == 'h26);
      end
    end
    oe = m_byte && (m_idx == 0) && ((c & 'h20) != 0);
    estat = m_hi ? (m_buf >> 4) & 15 : m_buf & 15;
    n_rd += rb_rd;
    n_wr += rb_wr;
    chk(cur_tag, "rb_wr", rb_wr, wr);
    chk(cur_tag, "rb_rd", rb_rd, rd);
    chk(cur_tag, "host_stat", host_stat, estat);
    chk(cur_tag, "host_oe", host_oe, oe);
    if (wr) begin
      chk(cur_tag, "rb_addr(wr)", rb_addr, a);
      chk(cur_tag, "rb_wdata", rb_wdata, d & 255);
    end
    if (rd) chk(cur_tag, "rb_addr(rd)", rb_addr, a);
    if (oe) chk(cur_tag, "host_dout", host_dout, m_buf);
    if (rd) begin m_buf = mdisk[a]; m_hi = 0; end
    else if (sethi) m_hi = 1;
    m_phase = nphase;
    if (ie || we) begin m_phase = 0; m_hi = 0; end
    if (wr) mdisk[a] = d & 255;
    if (we) begin
      m_last4 = 0;
      if (m_idx == 0) m_staged = wr ? 0 : 1;
      if (m_idx == 1) begin m_reg = (d >> 2) & 7; m_sel = (d >> 1) & 1; end
      if (m_idx == 2 && (d == 8 || d == 9 || d == 'h18 || d == 'h19)) begin
        m_blk = (d >> 4) & 1;
        m_byte = d & 1;
      end
    end
    if (ie) begin
      m_staged = 0;
      if (d == 4 && m_last4) begin
        m_idx = 4; m_byte = 0; m_blk = 0; m_reg = 0; m_sel = 0; m_last4 = 0;
      end else begin
        m_idx = d;
        m_last4 = (d == 4);
      end
    end
    m_prev = c;
    @(posedge clk);
    #1;
    obs_stat = host_stat;
    obs_out = host_dout;
    obs_oe = host_oe;
  endtask

  task automatic latch_index(int v);
    step(5, v); step(13, v); step(5, v); step(13, v); step(5, v); step(4, v);
  endtask

  task automatic data_pulse(int v);
    step(5, v); step(7, v); step(5, v); step(4, v);
  endtask

  task automatic set_addr(int r, int s);
    latch_index(1);
    data_pulse((r << 2) + 1 + s);
    latch_index(0);
  endtask

  task automatic set_mode(int m);
    latch_index(2);
    data_pulse(m);
  endtask

  task automatic nibble_read(output int val);
    int lo;
    step(6, 0); lo = obs_stat; step(4, 0);
    step(6, 0); val = (obs_stat << 4) | lo; step(4, 0);
    step(6, 0); step(4, 0); step(6, 0); step(4, 0);
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog R1 actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, rd0, wr0;
    for (int i = 0; i < 16; i++) begin
      disk[i] = 8'((i * 37 + 11) & 255);
      mdisk[i] = (i * 37 + 11) & 255;
    end
    m_prev = 4; m_idx = 0; m_reg = 0; m_sel = 0; m_byte = 0; m_blk = 0;
    m_staged = 0; m_last4 = 0; m_phase = 0; m_hi = 0; m_buf = 0;
    n_rd = 0; n_wr = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    cur_tag = "R1";
    step(4, 0);
    chk("R1", "reset stat", obs_stat, 0);
    chk("R1", "reset oe", obs_oe, 0);
    step(4, 0);

    cur_tag = "R3";
    set_addr(5, 0);
    cur_tag = "R5";
    wr0 = n_wr;
    data_pulse(8'hA7);
    chk("R5", "no commit on first pulse", n_wr - wr0, 0);
    data_pulse(8'hA7);
    chk("R5", "commit on second pulse", n_wr - wr0, 1);
    cur_tag = "R7";
    nibble_read(v);
    chk("R7", "nibble round trip", v, 8'hA7);

    cur_tag = "R3";
    set_addr(2, 1);
    data_pulse(8'h3C); data_pulse(8'h3C);
    nibble_read(v);
    chk("R3", "bank-select round trip", v, 8'h3C);

    cur_tag = "R6";
    set_mode(9);
    set_addr(5, 0);
    cur_tag = "R8";
    step(8'h26, 0);
    chk("R8", "byte read data", obs_out, 8'hA7);
    chk("R8", "byte read oe", obs_oe, 1);
    step(4, 0);
    chk("R8", "oe drops", obs_oe, 0);
    rd0 = n_rd;
    step(8'h26, 0); step(4, 0);
    chk("R8", "dummy strobe", n_rd - rd0, 0);

    cur_tag = "R6";
    set_mode(8'h55);
    latch_index(0);
    step(8'h26, 0);
    chk("R6", "bad code keeps byte mode", obs_oe, 1);
    step(4, 0);

    cur_tag = "R4";
    step(5, 3); step(13, 3); step(5, 3); step(8'h26, 3); step(4, 3);
    wr0 = n_wr;
    step(5, 8'h11); step(7, 8'h11); step(6, 8'h11); step(4, 8'h11);
    chk("R4", "stray write pulse", n_wr - wr0, 0);
    data_pulse(8'h96); data_pulse(8'h96);
    chk("R4", "index kept at 0", n_wr - wr0, 1);
    step(8'h26, 0);
    chk("R4", "write after stray", obs_out, 8'h96);
    step(4, 0);

    cur_tag = "R11";
    set_mode(8'h18);
    set_addr(0, 0);
    wr0 = n_wr;
    data_pulse(8'h5A);
    chk("R11", "block single-pulse commit", n_wr - wr0, 1);
    cur_tag = "R9";
    step(6, 0);
    chk("R9", "block low nibble", obs_stat, 4'hA);
    step(4, 0);
    chk("R9", "block high nibble", obs_stat, 4'h5);
    rd0 = n_rd;
    step(6, 0); step(4, 0);
    chk("R9", "block refetch", n_rd - rd0, 1);

    cur_tag = "R10";
    set_mode(8'h19);
    latch_index(0);
    data_pulse(8'h81);
    rd0 = n_rd;
    step(8'h26, 0);
    chk("R10", "byte block data", obs_out, 8'h81);
    step(8'h24, 0);
    step(4, 0);
    chk("R10", "two fetches", n_rd - rd0, 2);

    cur_tag = "R12";
    latch_index(3);
    rd0 = n_rd; wr0 = n_wr;
    step(8'h26, 0); step(8'h24, 0); step(6, 0); step(4, 0);
    data_pulse(8'hEE);
    chk("R12", "no read while closed", n_rd - rd0, 0);
    chk("R12", "no write while closed", n_wr - wr0, 0);

    cur_tag = "R13";
    set_mode(9);
    set_addr(3, 0);
    latch_index(4); latch_index(4);
    latch_index(0);
    step(8'h26, 0);
    chk("R13", "nibble mode restored", obs_oe, 0);
    step(4, 0);
    nibble_read(v);
    chk("R13", "address restored", v, 8'h81);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule